// File: doc/BRIEF.md
# Write Path Guard with Power-Up Lockout and Strobe Deglitch

This block sits in front of the write engine of a byte-wide nonvolatile memory. It watches a digital power-good flag and the raw active-low chip-select, write and read-enable strobes. It hands the write engine cleaned strobes and a single write-permit flag. Three protections share one gate.

The first protection is a timed hold-off. After power-good rises, writes stay blocked until a programmable number of clock cycles has passed. The second is a level interlock: no write is permitted while the chip is deselected, while the write strobe is inactive, or while the read enable is driven active. The third is a deglitch filter on the chip-select and write strobes. A strobe counts as asserted only after it has been seen low for a set number of consecutive clock samples, so short noise pulses never reach the write engine.

If power-good drops, the permit falls in the same cycle without waiting for a clock edge, and the hold-off starts again from zero.

Top module: `write_gate`

## Requirements
- R1: While reset is held and just after it is released, `writeAllow` is 0, `lockDone` is 0, and `ceFiltN` and `weFiltN` are both 1.
- R2: With `powerGood` held at 1, `lockDone` becomes 1 right after the LOCK_CYCLES-th rising clock edge that samples `powerGood` high. It stays 0 before that edge and stays 1 afterwards. `writeAllow` is 0 whenever `lockDone` is 0.
- R3: When `powerGood` is 0, `writeAllow` is 0 at once, with no clock edge needed. After the next edge `lockDone` is 0. Once `powerGood` returns to 1, the full LOCK_CYCLES hold-off is counted again.
- R4: `weFiltN` goes to 0 only after `weRawN` has been sampled 0 on MIN_WIDTH consecutive rising edges. A low pulse seen on fewer edges leaves `weFiltN` at 1 throughout.
- R5: `ceFiltN` obeys the same MIN_WIDTH consecutive-sample rule with respect to `ceRawN`.
- R6: A filtered strobe returns to 1 right after the first rising edge that samples its raw strobe at 1.
- R7: After an edge that samples `oeRawN` at 0, `writeAllow` is 0.
- R8: `writeAllow` is 1 exactly when `powerGood` is 1, `lockDone` is 1, `ceFiltN` is 0, `weFiltN` is 0, and `oeRawN` was 1 at the last edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| powerGood | input | 1 | Digital supply-good flag |
| ceRawN | input | 1 | Raw chip select, active low |
| weRawN | input | 1 | Raw write strobe, active low |
| oeRawN | input | 1 | Raw read enable, active low |
| ceFiltN | output | 1 | Deglitched chip select, active low |
| weFiltN | output | 1 | Deglitched write strobe, active low |
| writeAllow | output | 1 | Write permit for the write engine |
| lockDone | output | 1 | Power-up hold-off has elapsed |

## Verification
The bench builds the block with LOCK_CYCLES = 20 and MIN_WIDTH = 3. With a hold-off that short, the bench can walk through it edge by edge, both at first power-up and again after a power-good dropout. With a three-sample filter, it can sweep every pulse width from one sample to two beyond the threshold on each strobe, which covers the reject side, the pass side and the exact boundary. It also cycles through all eight level combinations of the three strobes and compares the permit with the value expected from the interlock rule.

// File: rtl/write_gate_pkg.sv
package write_gate_pkg;

  // Control-to-datapath strobe bundle
  typedef struct packed {
    logic pgNow;     // live power-good level
    logic lockDone;  // hold-off elapsed
    logic oeHigh;    // read enable sampled inactive
  } gateCtrl_t;

  function automatic int cntWidth(input int limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/write_gate_filt.sv
module write_gate_filt #(
  parameter int MIN_WIDTH = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawN,
  output logic filtN
);
  localparam int CW = write_gate_pkg::cntWidth(MIN_WIDTH);
  localparam logic [CW-1:0] RUN_MAX = CW'(MIN_WIDTH);

  logic [CW-1:0] lowRun;

  // Count consecutive low samples, saturating at the threshold.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                lowRun <= '0;
    else if (rawN)            lowRun <= '0;
    else if (lowRun != RUN_MAX) lowRun <= lowRun + 1'b1;
  end

  assign filtN = (lowRun != RUN_MAX);
endmodule

// File: rtl/write_gate_ctrl.sv
module write_gate_ctrl #(
  parameter int LOCK_CYCLES = 625000
) (
  input  logic clk,
  input  logic rstN,
  input  logic powerGood,
  input  logic oeRawN,
  output write_gate_pkg::gateCtrl_t ctrlBus
);
  localparam int LW = write_gate_pkg::cntWidth(LOCK_CYCLES);
  localparam logic [LW-1:0] LOCK_MAX = LW'(LOCK_CYCLES);

  logic [LW-1:0] lockCnt;
  logic          oeHigh;

  // Hold-off counter: cleared whenever power-good is low.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  lockCnt <= '0;
    else if (!powerGood)        lockCnt <= '0;
    else if (lockCnt != LOCK_MAX) lockCnt <= lockCnt + 1'b1;
  end

  // Read enable level, sampled once per cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) oeHigh <= 1'b0;
    else       oeHigh <= oeRawN;
  end

  always_comb begin
    ctrlBus.pgNow    = powerGood;
    ctrlBus.lockDone = (lockCnt == LOCK_MAX);
    ctrlBus.oeHigh   = oeHigh;
  end
endmodule

// File: rtl/write_gate_dp.sv
module write_gate_dp #(
  parameter int MIN_WIDTH = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic ceRawN,
  input  logic weRawN,
  input  write_gate_pkg::gateCtrl_t ctrlBus,
  output logic ceFiltN,
  output logic weFiltN,
  output logic writeAllow
);
  localparam int N_STROBE = 2;

  logic [N_STROBE-1:0] rawVec;
  logic [N_STROBE-1:0] filtVec;

  assign rawVec = {ceRawN, weRawN};

  // One deglitch filter per write-related strobe.
  for (genvar g = 0; g < N_STROBE; g++) begin : g_filt
    write_gate_filt #(.MIN_WIDTH(MIN_WIDTH)) i_filt (
      .clk  (clk),
      .rstN (rstN),
      .rawN (rawVec[g]),
      .filtN(filtVec[g])
    );
  end

  assign weFiltN = filtVec[0];
  assign ceFiltN = filtVec[1];

  // The single gate that combines all three protections.
  assign writeAllow = ctrlBus.pgNow & ctrlBus.lockDone & ctrlBus.oeHigh & ~(|filtVec);
endmodule

// File: rtl/write_gate.sv
module write_gate #(
  parameter int LOCK_CYCLES = 625000,
  parameter int MIN_WIDTH   = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic powerGood,
  input  logic ceRawN,
  input  logic weRawN,
  input  logic oeRawN,
  output logic ceFiltN,
  output logic weFiltN,
  output logic writeAllow,
  output logic lockDone
);
  write_gate_pkg::gateCtrl_t ctrlBus;

  write_gate_ctrl #(.LOCK_CYCLES(LOCK_CYCLES)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .powerGood(powerGood),
    .oeRawN   (oeRawN),
    .ctrlBus  (ctrlBus)
  );

  write_gate_dp #(.MIN_WIDTH(MIN_WIDTH)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ceRawN    (ceRawN),
    .weRawN    (weRawN),
    .ctrlBus   (ctrlBus),
    .ceFiltN   (ceFiltN),
    .weFiltN   (weFiltN),
    .writeAllow(writeAllow)
  );

  assign lockDone = ctrlBus.lockDone;
endmodule

// File: rtl/write_gate_chk.sv
module write_gate_chk (
  input logic clk,
  input logic rstN,
  input logic powerGood,
  input logic ceRawN,
  input logic weRawN,
  input logic oeRawN,
  input logic ceFiltN,
  input logic weFiltN,
  input logic writeAllow,
  input logic lockDone
);
  p_reset_idle_r1: assert property (@(posedge clk) !rstN |-> (!writeAllow && ceFiltN && weFiltN));

  p_lock_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockDone) |-> (powerGood && $past(powerGood)));

  p_pg_drop_r3: assert property (@(posedge clk) disable iff (!rstN)
    !powerGood |-> !writeAllow);

  p_lock_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    !powerGood |=> !lockDone);

  p_we_fall_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(weFiltN) |-> $past(!weRawN));

  p_ce_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ceFiltN) |-> $past(!ceRawN));

  p_we_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    weRawN |=> weFiltN);

  p_ce_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    ceRawN |=> ceFiltN);

  p_oe_block_r7: assert property (@(posedge clk) disable iff (!rstN)
    !oeRawN |=> !writeAllow);

  p_allow_needs_r8: assert property (@(posedge clk) disable iff (!rstN)
    writeAllow |-> (!ceFiltN && !weFiltN && lockDone && powerGood));
endmodule

bind write_gate write_gate_chk i_write_gate_chk (
  .clk       (clk),
  .rstN      (rstN),
  .powerGood (powerGood),
  .ceRawN    (ceRawN),
  .weRawN    (weRawN),
  .oeRawN    (oeRawN),
  .ceFiltN   (ceFiltN),
  .weFiltN   (weFiltN),
  .writeAllow(writeAllow),
  .lockDone  (lockDone)
);

// File: tb/test_write_gate.sv
`timescale 1ns/1ps
module test_write_gate;
  localparam int LOCK = 20;
  localparam int MINW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic powerGood = 1'b0;
  logic ceRawN = 1'b1;
  logic weRawN = 1'b1;
  logic oeRawN = 1'b1;
  logic ceFiltN, weFiltN, writeAllow, lockDone;

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  write_gate #(.LOCK_CYCLES(LOCK), .MIN_WIDTH(MINW)) i_write_gate (
    .clk(clk), .rstN(rstN), .powerGood(powerGood),
    .ceRawN(ceRawN), .weRawN(weRawN), .oeRawN(oeRawN),
    .ceFiltN(ceFiltN), .weFiltN(weFiltN),
    .writeAllow(writeAllow), .lockDone(lockDone)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic stepN(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #1;
    // R1: state under reset and right after release
    stepN(2);
    chk(writeAllow, 1'b0, "R1 allow in reset");
    chk(lockDone,   1'b0, "R1 lock in reset");
    chk(ceFiltN,    1'b1, "R1 ce in reset");
    chk(weFiltN,    1'b1, "R1 we in reset");
    rstN = 1'b1;
    step();
    chk(writeAllow, 1'b0, "R1 allow after release");
    chk(lockDone,   1'b0, "R1 lock after release");

    // R2: hold-off counted edge by edge, strobes already asserted
    ceRawN = 1'b0; weRawN = 1'b0; oeRawN = 1'b1;
    stepN(MINW);
    powerGood = 1'b1;
    for (int k = 1; k <= LOCK + 2; k++) begin
      step();
      chk(lockDone,   (k >= LOCK) ? 1'b1 : 1'b0, "R2 lockDone timing");
      chk(writeAllow, (k >= LOCK) ? 1'b1 : 1'b0, "R2/R8 permit follows lockout");
    end

    // R3: power-good drop is seen at once and restarts the hold-off
    #1 powerGood = 1'b0;
    #1 chk(writeAllow, 1'b0, "R3 permit drops without edge");
    step();
    chk(lockDone, 1'b0, "R3 lock cleared");
    powerGood = 1'b1;
    for (int k = 1; k <= LOCK; k++) begin
      step();
      chk(lockDone, (k >= LOCK) ? 1'b1 : 1'b0, "R3 hold-off restarted");
    end
    chk(writeAllow, 1'b1, "R3 permit after restart");

    // R4/R6: write strobe pulse-width sweep, chip select held active
    weRawN = 1'b1;
    stepN(2);
    for (int w = 1; w <= MINW + 2; w++) begin
      weRawN = 1'b0;
      for (int s = 1; s <= w; s++) begin
        step();
        chk(weFiltN,    (s >= MINW) ? 1'b0 : 1'b1, "R4 we filter");
        chk(writeAllow, (s >= MINW) ? 1'b1 : 1'b0, "R4/R8 permit on we");
      end
      weRawN = 1'b1;
      step();
      chk(weFiltN,    1'b1, "R6 we release");
      chk(writeAllow, 1'b0, "R6 permit after we release");
      step();
    end

    // R5/R6: chip-select pulse-width sweep, write strobe held active
    weRawN = 1'b0; ceRawN = 1'b1;
    stepN(MINW + 1);
    for (int w = 1; w <= MINW + 2; w++) begin
      ceRawN = 1'b0;
      for (int s = 1; s <= w; s++) begin
        step();
        chk(ceFiltN,    (s >= MINW) ? 1'b0 : 1'b1, "R5 ce filter");
        chk(writeAllow, (s >= MINW) ? 1'b1 : 1'b0, "R5/R8 permit on ce");
      end
      ceRawN = 1'b1;
      step();
      chk(ceFiltN, 1'b1, "R6 ce release");
      step();
    end

    // R7: read enable active blocks the permit
    ceRawN = 1'b0; weRawN = 1'b0;
    stepN(MINW);
    chk(writeAllow, 1'b1, "R7 baseline permit");
    oeRawN = 1'b0;
    step();
    chk(writeAllow, 1'b0, "R7 oe low blocks");
    oeRawN = 1'b1;
    step();
    chk(writeAllow, 1'b1, "R7 oe high restores");

    // R8: every level combination of ce, we, oe
    for (int c = 0; c < 8; c++) begin
      ceRawN = c[0]; weRawN = c[1]; oeRawN = c[2];
      stepN(MINW);
      chk(writeAllow, (!c[0] && !c[1] && c[2]) ? 1'b1 : 1'b0, "R8 level combination");
    end

    finished = 1'b1;
  end

  initial begin
    for (int t = 0; t < 5000; t++) begin
      if (finished) break;
      @(posedge clk);
    end
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule